// File: doc/BRIEF.md
# Indexed RTC Register Interface

This block is the host-facing register bank of a real-time clock. A host reaches every register through two ports. A write to the index port selects a register. Later data-port reads and writes go to that register until the index is written again. The bank holds the ten time-of-day and alarm bytes, four control and status registers, and fifty bytes of general storage.

The bank exports the mode, enable and set bits to the timekeeping and rate logic next to it. It accepts a byte-wide load port from the timekeeper, which the set bit blocks. It takes back the update-end, alarm and periodic event pulses and records them as flags in a status register. A summary bit in that register drives the interrupt request output.

Top module: `rtc_regbank`

## Requirements
- R1: An index-port write selects a register. A data-port write in a later cycle stores `wdata_i` into the selected register. A data-port read in a later cycle returns it on `rdata_o`.
- R2: Indices 0x00–0x09 are time/alarm bytes, with byte i on `tod_o[8*i+7:8*i]`. Indices 0x0A–0x0D are control registers A–D. Indices 0x0E–0x3F are fifty storage bytes. Indices 0x40 and above read as 0x00, and writes to them change nothing.
- R3: Register A bit 7 reads the live level of `upd_busy_i` and cannot be written. Bits 6:4 drive `div_sel_o`. Bits 3:0 drive `rate_sel_o`.
- R4: Register B bit 0 drives `dst_en_o`, bit 1 `hr24_o`, bit 2 `binary_o` and bit 3 `sqw_en_o`. Bit 4 is the update-end interrupt enable, bit 5 the alarm enable and bit 6 the periodic enable. Bit 7 is the set bit and drives `set_o`.
- R5: While register B bit 7 is 1, timekeeper loads (`tk_we_i`) leave the time bytes unchanged. While it is 0, a load writes `tk_data_i` into byte `tk_idx_i`.
- R6: A pulse on `upd_end_i` sets register C bit 4. A pulse on `alarm_hit_i` sets bit 5. A pulse on `periodic_i` sets bit 6. Bit 7 is 1 while any of bits 6:4 is 1 and its enable in register B is 1. `irq_o` equals bit 7.
- R7: A data-port read of register C returns its contents and clears bits 6:4. An event in the same cycle as that read is set after the read and appears on the next read.
- R8: Data-port writes to registers C and D are ignored. Register D reads as `{ram_valid_i, 7'b0}`.
- R9: `rdata_o` is registered. It updates one clock edge after a read strobe and holds until the next read. The index persists across any number of data accesses.
- R10: After reset, `rdata_o`, `irq_o`, `set_o` and all time bytes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| idx_we_i | input | 1 | Index port write strobe |
| dat_we_i | input | 1 | Data port write strobe |
| dat_re_i | input | 1 | Data port read strobe |
| wdata_i | input | 8 | Write data for the index or data port |
| rdata_o | output | 8 | Registered read data |
| upd_busy_i | input | 1 | Update-in-progress level from the timekeeper |
| ram_valid_i | input | 1 | Valid RAM and time level |
| upd_end_i | input | 1 | Update-end event pulse |
| alarm_hit_i | input | 1 | Alarm event pulse |
| periodic_i | input | 1 | Periodic event pulse |
| tk_we_i | input | 1 | Timekeeper load strobe |
| tk_idx_i | input | 4 | Timekeeper load byte index |
| tk_data_i | input | 8 | Timekeeper load data |
| tod_o | output | 80 | Time and alarm bytes, flattened |
| div_sel_o | output | 3 | Divider select |
| rate_sel_o | output | 4 | Periodic rate select |
| dst_en_o | output | 1 | Daylight-saving enable |
| hr24_o | output | 1 | 24-hour mode |
| binary_o | output | 1 | Binary (not BCD) mode |
| sqw_en_o | output | 1 | Square-wave enable |
| set_o | output | 1 | Set bit, freezes updates |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
Each register write, flag update and read result lands on the first clock edge after its strobe. Exported bits, tod bytes and `irq_o` are therefore due one edge after the write or pulse, and `rdata_o` one edge after the read strobe. Only register D bit 7 and register A bit 7 follow their inputs without delay, and they are checked through a read. The bench changes inputs on the falling edge and clears every strobe at the next falling edge. It compares outputs at that same falling edge, half a period after the rising edge that acted on them, so each check sees exactly one edge of effect.

// File: rtl/rtc_regbank_pkg.sv
package rtc_regbank_pkg;
  localparam int unsigned DW     = 8;
  localparam int unsigned IDX_W  = 7;
  localparam int unsigned N_TOD  = 10;
  localparam int unsigned N_NV   = 50;
  localparam int unsigned TOD_AW = $clog2(N_TOD);
  localparam int unsigned NV_AW  = $clog2(N_NV);
  localparam logic [IDX_W-1:0] IDX_A    = IDX_W'(N_TOD);
  localparam logic [IDX_W-1:0] IDX_B    = IDX_W'(N_TOD + 1);
  localparam logic [IDX_W-1:0] IDX_C    = IDX_W'(N_TOD + 2);
  localparam logic [IDX_W-1:0] IDX_D    = IDX_W'(N_TOD + 3);
  localparam logic [IDX_W-1:0] NV_BASE  = IDX_W'(N_TOD + 4);
  localparam logic [IDX_W-1:0] NV_LIMIT = IDX_W'(N_TOD + 4 + N_NV);

  typedef struct packed {
    logic set;
    logic pie;
    logic aie;
    logic uie;
    logic sqwe;
    logic bin;
    logic hr24;
    logic dse;
  } regb_t;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_TOD, SEL_A, SEL_B, SEL_C, SEL_D, SEL_NV
  } sel_e;
endpackage

// File: rtl/rtc_index_port.sv
module rtc_index_port
  import rtc_regbank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idx_we_i,
  input  logic [DW-1:0]     wdata_i,
  output sel_e              sel_o,
  output logic [TOD_AW-1:0] tod_off_o,
  output logic [NV_AW-1:0]  nv_off_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       idx_q <= '0;
    else if (idx_we_i) idx_q <= wdata_i[IDX_W-1:0];
  end

  always_comb begin
    if (idx_q < IDX_A)         sel_o = SEL_TOD;
    else if (idx_q == IDX_A)   sel_o = SEL_A;
    else if (idx_q == IDX_B)   sel_o = SEL_B;
    else if (idx_q == IDX_C)   sel_o = SEL_C;
    else if (idx_q == IDX_D)   sel_o = SEL_D;
    else if (idx_q < NV_LIMIT) sel_o = SEL_NV;
    else                       sel_o = SEL_NONE;
  end

  assign tod_off_o = TOD_AW'(idx_q);
  assign nv_off_o  = NV_AW'(idx_q - NV_BASE);
  assign idx_o     = idx_q;
endmodule

// File: rtl/rtc_byte_store.sv
module rtc_byte_store #(
  parameter int unsigned N  = 10,
  parameter int unsigned DW = 8,
  parameter int unsigned AW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hwe_i,
  input  logic [AW-1:0]   hidx_i,
  input  logic [DW-1:0]   hdata_i,
  input  logic            lwe_i,
  input  logic [AW-1:0]   lidx_i,
  input  logic [DW-1:0]   ldata_i,
  input  logic [AW-1:0]   ridx_i,
  output logic [DW-1:0]   rdata_o,
  output logic [N*DW-1:0] flat_o
);
  logic [DW-1:0] mem [N];

  for (genvar g = 0; g < N; g++) begin : g_byte
    // host port wins over load port on the same byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          mem[g] <= '0;
      else if (hwe_i && hidx_i == AW'(g))   mem[g] <= hdata_i;
      else if (lwe_i && lidx_i == AW'(g))   mem[g] <= ldata_i;
    end
    assign flat_o[g*DW +: DW] = mem[g];
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N; i++)
      if (ridx_i == AW'(i)) rdata_o = mem[i];
  end
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_regbank_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_a_i,
  input  logic          we_b_i,
  input  logic          re_c_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          busy_i,
  input  logic          vrt_i,
  input  logic          ev_upd_i,
  input  logic          ev_alm_i,
  input  logic          ev_per_i,
  output logic [DW-1:0] rega_o,
  output regb_t         regb_o,
  output logic [DW-1:0] regc_o,
  output logic [DW-1:0] regd_o,
  output logic          irq_o
);
  logic [DW-2:0] rega_q;
  regb_t         regb_q;
  logic [2:0]    flag_q;  // [0] update-end, [1] alarm, [2] periodic
  logic [2:0]    ev;
  logic          irqf;

  assign ev = {ev_per_i, ev_alm_i, ev_upd_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rega_q <= '0;
      regb_q <= '0;
      flag_q <= '0;
    end else begin
      if (we_a_i) rega_q <= wdata_i[DW-2:0];
      if (we_b_i) regb_q <= regb_t'(wdata_i);
      // read clears; same-cycle events survive
      if (re_c_i) flag_q <= ev;
      else        flag_q <= flag_q | ev;
    end
  end

  assign irqf   = |(flag_q & {regb_q.pie, regb_q.aie, regb_q.uie});
  assign rega_o = {busy_i, rega_q};
  assign regb_o = regb_q;
  assign regc_o = {irqf, flag_q, 4'b0000};
  assign regd_o = {vrt_i, 7'b0};
  assign irq_o  = irqf;

  // R6
  upd_flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_upd_i |=> regc_o[4]);
  // R6
  per_flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_per_i |=> regc_o[6]);
  // R7
  rdc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_c_i && !ev_upd_i && !ev_alm_i && !ev_per_i) |=> (regc_o[6:4] == 3'b000));
  // R6
  irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (regc_o[6:4] != 3'b000));
endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
  import rtc_regbank_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               idx_we_i,
  input  logic               dat_we_i,
  input  logic               dat_re_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  input  logic               upd_busy_i,
  input  logic               ram_valid_i,
  input  logic               upd_end_i,
  input  logic               alarm_hit_i,
  input  logic               periodic_i,
  input  logic               tk_we_i,
  input  logic [3:0]         tk_idx_i,
  input  logic [7:0]         tk_data_i,
  output logic [79:0]        tod_o,
  output logic [2:0]         div_sel_o,
  output logic [3:0]         rate_sel_o,
  output logic               dst_en_o,
  output logic               hr24_o,
  output logic               binary_o,
  output logic               sqw_en_o,
  output logic               set_o,
  output logic               irq_o
);
  sel_e              sel;
  logic [TOD_AW-1:0] tod_off;
  logic [NV_AW-1:0]  nv_off;
  logic [IDX_W-1:0]  idx;
  logic [DW-1:0]     tod_rd, nv_rd, rega, regc, regd, rd_mux, rdata_q;
  regb_t             regb;
  logic              tod_lwe;

  rtc_index_port u_idx (
    .clk_i, .rst_ni, .idx_we_i, .wdata_i,
    .sel_o(sel), .tod_off_o(tod_off), .nv_off_o(nv_off), .idx_o(idx)
  );

  assign tod_lwe = tk_we_i && !regb.set;

  rtc_byte_store #(.N(N_TOD), .DW(DW), .AW(TOD_AW)) u_tod (
    .clk_i, .rst_ni,
    .hwe_i(dat_we_i && sel == SEL_TOD), .hidx_i(tod_off), .hdata_i(wdata_i),
    .lwe_i(tod_lwe), .lidx_i(tk_idx_i), .ldata_i(tk_data_i),
    .ridx_i(tod_off), .rdata_o(tod_rd), .flat_o(tod_o)
  );

  rtc_byte_store #(.N(N_NV), .DW(DW), .AW(NV_AW)) u_nv (
    .clk_i, .rst_ni,
    .hwe_i(dat_we_i && sel == SEL_NV), .hidx_i(nv_off), .hdata_i(wdata_i),
    .lwe_i(1'b0), .lidx_i('0), .ldata_i('0),
    .ridx_i(nv_off), .rdata_o(nv_rd), .flat_o()
  );

  rtc_ctrl_regs u_ctrl (
    .clk_i, .rst_ni,
    .we_a_i(dat_we_i && sel == SEL_A),
    .we_b_i(dat_we_i && sel == SEL_B),
    .re_c_i(dat_re_i && sel == SEL_C),
    .wdata_i, .busy_i(upd_busy_i), .vrt_i(ram_valid_i),
    .ev_upd_i(upd_end_i), .ev_alm_i(alarm_hit_i), .ev_per_i(periodic_i),
    .rega_o(rega), .regb_o(regb), .regc_o(regc), .regd_o(regd), .irq_o
  );

  always_comb begin
    unique case (sel)
      SEL_TOD: rd_mux = tod_rd;
      SEL_A:   rd_mux = rega;
      SEL_B:   rd_mux = regb;
      SEL_C:   rd_mux = regc;
      SEL_D:   rd_mux = regd;
      SEL_NV:  rd_mux = nv_rd;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (dat_re_i) rdata_q <= rd_mux;
  end

  assign rdata_o    = rdata_q;
  assign div_sel_o  = rega[6:4];
  assign rate_sel_o = rega[3:0];
  assign dst_en_o   = regb.dse;
  assign hr24_o     = regb.hr24;
  assign binary_o   = regb.bin;
  assign sqw_en_o   = regb.sqwe;
  assign set_o      = regb.set;

  // R3
  busy_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_re_i && idx == IDX_A) |=> (rdata_o[7] == $past(upd_busy_i)));
  // R2
  oor_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_re_i && idx >= NV_LIMIT) |=> (rdata_o == 8'h00));
  // R5
  set_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_o && !(dat_we_i && idx < IDX_A)) |=> $stable(tod_o));
  // R9
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dat_re_i |=> $stable(rdata_o));
  // R8
  c_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_we_i && !dat_re_i && idx == IDX_C && !upd_end_i && !alarm_hit_i && !periodic_i)
      |=> $stable(regc));
endmodule

// File: tb/rtc_regbank_tb.sv
module rtc_regbank_tb;
  logic clk = 0, rst_ni = 0;
  logic idx_we_i = 0, dat_we_i = 0, dat_re_i = 0;
  logic [7:0] wdata_i = 0, rdata_o;
  logic upd_busy_i = 0, ram_valid_i = 0, upd_end_i = 0, alarm_hit_i = 0, periodic_i = 0;
  logic tk_we_i = 0;
  logic [3:0] tk_idx_i = 0;
  logic [7:0] tk_data_i = 0;
  logic [79:0] tod_o;
  logic [2:0] div_sel_o;
  logic [3:0] rate_sel_o;
  logic dst_en_o, hr24_o, binary_o, sqw_en_o, set_o, irq_o;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  rtc_regbank u_dut (.clk_i(clk), .*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_idx(logic [7:0] i);
    @(negedge clk); idx_we_i = 1; wdata_i = i;
    @(negedge clk); idx_we_i = 0;
  endtask
  task automatic wr(logic [7:0] d);
    @(negedge clk); dat_we_i = 1; wdata_i = d;
    @(negedge clk); dat_we_i = 0;
  endtask
  task automatic rd(string req, logic [7:0] exp);
    @(negedge clk); dat_re_i = 1;
    @(negedge clk); dat_re_i = 0;
    chk(req, rdata_o, exp);
  endtask

  task automatic t_reset;
    chk("R10 rdata", rdata_o, 0);
    chk("R10 irq", irq_o, 0);
    chk("R10 set", set_o, 0);
    chk("R10 tod", tod_o[31:0], 0);
  endtask

  task automatic t_basic;
    set_idx(8'h03); wr(8'h11);
    chk("R1/R2 tod byte3", tod_o[31:24], 8'h11);
    rd("R1 readback", 8'h11);
    rd("R9 index held", 8'h11);
    @(negedge clk);
    chk("R9 rdata holds", rdata_o, 8'h11);
    set_idx(8'h09); wr(8'h99);
    chk("R2 tod byte9", tod_o[79:72], 8'h99);
  endtask

  task automatic t_map;
    set_idx(8'h0E); wr(8'hA5);
    set_idx(8'h3F); wr(8'h3C);
    set_idx(8'h0E); rd("R2 first storage", 8'hA5);
    set_idx(8'h40); wr(8'h77); rd("R2 out of range 0x40", 8'h00);
    set_idx(8'h7F); rd("R2 out of range 0x7F", 8'h00);
    set_idx(8'h3F); rd("R2 last storage intact", 8'h3C);
  endtask

  task automatic t_rega;
    set_idx(8'h0A); wr(8'hFF);
    chk("R3 div_sel", div_sel_o, 3'h7);
    chk("R3 rate_sel", rate_sel_o, 4'hF);
    rd("R3 bit7 not written", 8'h7F);
    upd_busy_i = 1;
    rd("R3 busy reads 1", 8'hFF);
    upd_busy_i = 0;
  endtask

  task automatic t_regb;
    set_idx(8'h0B); wr(8'h0F);
    chk("R4 mode bits", {sqw_en_o, binary_o, hr24_o, dst_en_o}, 4'hF);
    chk("R4 set clear", set_o, 0);
    rd("R4 readback", 8'h0F);
    wr(8'h05);
    chk("R4 pattern 05", {sqw_en_o, binary_o, hr24_o, dst_en_o}, 4'h5);
  endtask

  task automatic t_set;
    set_idx(8'h0B); wr(8'h80);
    chk("R4 set_o", set_o, 1);
    @(negedge clk); tk_we_i = 1; tk_idx_i = 0; tk_data_i = 8'h55;
    @(negedge clk); tk_we_i = 0;
    chk("R5 frozen", tod_o[7:0], 8'h00);
    wr(8'h00);
    @(negedge clk); tk_we_i = 1;
    @(negedge clk); tk_we_i = 0;
    chk("R5 load allowed", tod_o[7:0], 8'h55);
  endtask

  task automatic t_flags;
    set_idx(8'h0B); wr(8'h00);
    set_idx(8'h0C);
    @(negedge clk); upd_end_i = 1;
    @(negedge clk); upd_end_i = 0;
    chk("R6 masked no irq", irq_o, 0);
    @(negedge clk); dat_re_i = 1; alarm_hit_i = 1;
    @(negedge clk); dat_re_i = 0; alarm_hit_i = 0;
    chk("R7 read returns prior", rdata_o, 8'h10);
    rd("R7 same-cycle event kept", 8'h20);
    rd("R7 cleared", 8'h00);
    set_idx(8'h0B); wr(8'h40);
    set_idx(8'h0C);
    @(negedge clk); periodic_i = 1;
    @(negedge clk); periodic_i = 0;
    chk("R6 irq asserted", irq_o, 1);
    rd("R6 summary bit", 8'hC0);
    chk("R7 irq cleared by read", irq_o, 0);
  endtask

  task automatic t_ro;
    set_idx(8'h0C); wr(8'hFF);
    rd("R8 C write ignored", 8'h00);
    chk("R8 no irq", irq_o, 0);
    set_idx(8'h0D); ram_valid_i = 1; wr(8'hFF);
    rd("R8 D valid", 8'h80);
    ram_valid_i = 0;
    rd("R8 D invalid", 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    @(negedge clk);
    t_basic();
    t_map();
    t_rega();
    t_regb();
    t_set();
    t_flags();
    t_ro();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule